// File: doc/BRIEF.md
# Push-Button Symbol Sequence Detector

The block takes four symbol buttons and one initialise button straight from a board. It filters contact bounce on each of them and turns every clean press into a single symbol event. Symbol buttons carry the values 1 to 4. After each initialise, a session accepts at most ten symbols. The block searches those symbols for the ordered code 2, 3, 1, 4, 3, which may start at any position in the session.

When the code is found, the whole LED bank flashes at a slow rate set by a clock divider. When ten symbols pass without the code, the session locks and the LEDs show a fixed alternating pattern. In both end states further symbol presses do nothing. Only the initialise button opens a new session. The debounce length and the divider ratio are parameters, so the board can use large values and a bench can use small ones.

Top module: `symseq_detector`

## Requirements
- R1: While `rst` is high and afterwards until the first accepted symbol, `led` is all zeros and the session is empty. Reset is synchronous and active high.
- R2: A raw button input counts as pressed only after it has been high on DEB_CYCLES consecutive clock edges. A shorter high pulse produces no event. A bouncing press produces exactly one event.
- R3: Bit i of `key_raw` enters symbol i+1. Each press gives one single-cycle symbol event on the rising edge of its debounced level, however long the button is held. A cycle in which more than one symbol button is debounced-down gives no event, and such a press does not count toward the session limit.
- R4: The code 2,3,1,4,3 is detected wherever it starts in the session. On a mismatch, the progress falls back to one matched symbol if the offending symbol is 2, and to zero otherwise.
- R5: After MAX_SYMS (10) accepted symbols without a match, the session locks. `led[i]` is then 1 for even i and 0 for odd i, so `led[0]` is on (12'h555 for 12 LEDs).
- R6: If the code completes on the tenth symbol, the session detects and does not lock.
- R7: While locked or detected, symbol presses are ignored and the LED behaviour is unchanged.
- R8: On detection, all LEDs turn on together. They then alternate between all on and all off, each phase lasting FLASH_DIV clock cycles.
- R9: A debounced press of `init_raw` clears the match progress and the symbol count and returns to an open session with `led` all zeros, from any state.
- R10: In an open session with fewer than ten symbols and no match, `led` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_raw | input | NUM_KEYS | Raw symbol buttons, bit i enters symbol i+1 |
| init_raw | input | 1 | Raw initialise button |
| led | output | LED_W | LED bank: dark, flashing, or lock pattern |

## Verification
On every cycle, the assertions check the debouncer rules: a level rises only after a high input and drops as soon as the input falls. They also check that symbol events last one cycle, that a finished session stays frozen until initialise, that initialise clears the session, that a completed code always wins over the lock, and that the flash phase holds between divider ticks and flips on each tick. Only the bench scenarios can show the end-to-end results: detection at several start offsets, the fallback after a partial match, the ten-symbol limit, the rejection of glitches, bounces and two-button presses, and the flash period measured at the LEDs.

// File: rtl/symseq_pkg.sv
package symseq_pkg;

  localparam int PAT_LEN = 5;
  localparam int SYM_W   = 3;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [2:0]       prog_t;

  typedef enum logic [1:0] {
    SES_RUN   = 2'd0,
    SES_FOUND = 2'd1,
    SES_LOCK  = 2'd2
  } ses_t;

  // Symbol expected at a given match position of the code 2 3 1 4 3.
  function automatic sym_t pat_sym(input prog_t idx);
    case (idx)
      3'd0:    return sym_t'(2);
      3'd1:    return sym_t'(3);
      3'd2:    return sym_t'(1);
      3'd3:    return sym_t'(4);
      default: return sym_t'(3);
    endcase
  endfunction

  // Progress after one symbol. No proper prefix of the code is also a
  // suffix, so a mismatch restarts at 1 if the symbol opens the code, else 0.
  function automatic prog_t next_prog(input prog_t p, input sym_t s);
    if (s == pat_sym(p))          return p + prog_t'(1);
    else if (s == pat_sym(3'd0))  return prog_t'(1);
    else                          return prog_t'(0);
  endfunction

endpackage

// File: rtl/symseq_debounce.sv
module symseq_debounce #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);

  logic [CW-1:0] run_cnt;
  logic          lvl_q;
  logic          lvl_d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      lvl_q   <= 1'b0;
      lvl_d1  <= 1'b0;
    end else begin
      lvl_d1 <= lvl_q;
      if (!raw) begin
        run_cnt <= '0;
        lvl_q   <= 1'b0;
      end else if (run_cnt == CW'(STABLE_CYCLES - 1)) begin
        lvl_q <= 1'b1;
      end else begin
        run_cnt <= run_cnt + CW'(1);
      end
    end
  end

  assign level = lvl_q;
  assign rise  = lvl_q & ~lvl_d1;

  // R2: the debounced level only comes up after the input was high
  a_r2_rise_needs_high: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_q) |-> $past(raw));

  // R2: a low input drops the level at the next edge
  a_r2_low_drops: assert property (@(posedge clk) disable iff (rst)
    !raw |=> !lvl_q);

  // R3: a press edge lasts one cycle
  a_r3_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/symseq_matcher.sv
module symseq_matcher
  import symseq_pkg::*;
#(
  parameter int MAX_SYMS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic init_evt,
  input  logic sym_valid,
  input  sym_t sym,
  output ses_t mode
);
  localparam int CNTW = $clog2(MAX_SYMS + 1);

  logic [CNTW-1:0] count;
  prog_t           prog;
  prog_t           prog_nx;
  logic            accept;
  logic            hit_now;
  logic            last_now;

  assign accept   = sym_valid && (mode == SES_RUN) && !init_evt;
  assign prog_nx  = next_prog(prog, sym);
  assign hit_now  = accept && (prog_nx == prog_t'(PAT_LEN));
  assign last_now = accept && (count == CNTW'(MAX_SYMS - 1));

  always_ff @(posedge clk) begin
    if (rst || init_evt) begin
      mode  <= SES_RUN;
      count <= '0;
      prog  <= '0;
    end else if (accept) begin
      count <= count + CNTW'(1);
      prog  <= hit_now ? prog_t'(0) : prog_nx;
      if (hit_now)       mode <= SES_FOUND;
      else if (last_now) mode <= SES_LOCK;
    end
  end

  // R7: a finished session is frozen until initialise
  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode != SES_RUN && !init_evt) |=> (mode == $past(mode)) && $stable(count));

  // R9: initialise empties the session
  a_r9_init_clears: assert property (@(posedge clk) disable iff (rst)
    init_evt |=> (mode == SES_RUN) && (count == '0) && (prog == '0));

  // R6: a completed code is never turned into a lock
  a_r6_hit_wins: assert property (@(posedge clk) disable iff (rst)
    hit_now |=> mode == SES_FOUND);

  // R5: a lock is only entered with a full session
  a_r5_lock_full: assert property (@(posedge clk) disable iff (rst)
    (mode == SES_LOCK && $past(mode) != SES_LOCK) |-> count == CNTW'(MAX_SYMS));

  // R4: progress stays inside the code length
  a_r4_prog_range: assert property (@(posedge clk) disable iff (rst)
    prog < prog_t'(PAT_LEN));

endmodule

// File: rtl/symseq_flash.sv
module symseq_flash #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic phase
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_cnt;
  logic          tick;

  assign tick = en && (div_cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_cnt <= '0;
      phase   <= 1'b1;
    end else if (tick) begin
      div_cnt <= '0;
      phase   <= ~phase;
    end else begin
      div_cnt <= div_cnt + CW'(1);
    end
  end

  // R8: the phase holds between divider ticks
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(phase));

  // R8: each tick flips the phase
  a_r8_toggle: assert property (@(posedge clk) disable iff (rst)
    tick |=> phase != $past(phase));

endmodule

// File: rtl/symseq_detector.sv
module symseq_detector
  import symseq_pkg::*;
#(
  parameter int NUM_KEYS   = 4,
  parameter int DEB_CYCLES = 100000,
  parameter int FLASH_DIV  = 25000000,
  parameter int MAX_SYMS   = 10,
  parameter int LED_W      = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] key_raw,
  input  logic                init_raw,
  output logic [LED_W-1:0]    led
);

  logic [NUM_KEYS-1:0] key_lvl;
  logic [NUM_KEYS-1:0] key_rise;
  logic                init_lvl;
  logic                init_rise;
  logic                sym_valid;
  sym_t                sym;
  ses_t                mode;
  logic                flash_phase;
  logic [LED_W-1:0]    lock_pat;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    symseq_debounce #(.STABLE_CYCLES(DEB_CYCLES)) u_deb (
      .clk   (clk),
      .rst   (rst),
      .raw   (key_raw[k]),
      .level (key_lvl[k]),
      .rise  (key_rise[k])
    );
  end

  symseq_debounce #(.STABLE_CYCLES(DEB_CYCLES)) u_init_deb (
    .clk   (clk),
    .rst   (rst),
    .raw   (init_raw),
    .level (init_lvl),
    .rise  (init_rise)
  );

  // One event only when exactly one symbol button is down.
  assign sym_valid = (key_rise != '0) && ($countones(key_lvl) == 1);

  always_comb begin
    sym = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (key_rise[i]) sym = sym_t'(i + 1);
    end
  end

  symseq_matcher #(.MAX_SYMS(MAX_SYMS)) u_match (
    .clk       (clk),
    .rst       (rst),
    .init_evt  (init_rise),
    .sym_valid (sym_valid),
    .sym       (sym),
    .mode      (mode)
  );

  symseq_flash #(.DIV(FLASH_DIV)) u_flash (
    .clk   (clk),
    .rst   (rst),
    .en    (mode == SES_FOUND),
    .phase (flash_phase)
  );

  for (genvar b = 0; b < LED_W; b++) begin : g_lock
    assign lock_pat[b] = ((b % 2) == 0);
  end

  always_comb begin
    case (mode)
      SES_FOUND: led = {LED_W{flash_phase}};
      SES_LOCK:  led = lock_pat;
      default:   led = '0;
    endcase
  end

  // R3: a symbol event is a one-cycle pulse
  a_r3_event_pulse: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid);

  // R9: an initialise event comes from a held button
  a_r9_init_held: assert property (@(posedge clk) disable iff (rst)
    init_rise |=> init_lvl || !init_raw);

endmodule

// File: tb/symseq_detector_bench.sv
`timescale 1ns/1ps
module symseq_detector_bench;

  localparam int NK    = 4;
  localparam int DEB   = 4;
  localparam int FDIV  = 8;
  localparam int LW    = 12;
  localparam logic [LW-1:0] LOCK_PAT = 12'h555;
  localparam logic [LW-1:0] ALL_ON   = 12'hFFF;
  localparam logic [LW-1:0] DARK     = 12'h000;

  typedef struct {
    logic [LW-1:0] val;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NK-1:0] key_raw = '0;
  logic          init_raw = 1'b0;
  logic [LW-1:0] led;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  exp_t exp_q[$];
  event chk_ev;

  always #2.5 clk = ~clk;

  symseq_detector #(
    .NUM_KEYS(NK), .DEB_CYCLES(DEB), .FLASH_DIV(FDIV), .MAX_SYMS(10), .LED_W(LW)
  ) u_symseq_detector (
    .clk(clk), .rst(rst), .key_raw(key_raw), .init_raw(init_raw), .led(led)
  );

  task automatic check(input logic [LW-1:0] act, input logic [LW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: led=%h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops expected LED states and compares them.
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(led, e.val, e.req);
      end
    end
  end

  task automatic expect_led(input logic [LW-1:0] v, input string req);
    exp_t e;
    e.val = v;
    e.req = req;
    exp_q.push_back(e);
    -> chk_ev;
  endtask

  task automatic press(input int s);
    @(negedge clk); key_raw[s-1] = 1'b1;
    repeat (6) @(negedge clk);
    key_raw[s-1] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic press_long(input int s);
    @(negedge clk); key_raw[s-1] = 1'b1;
    repeat (20) @(negedge clk);
    key_raw[s-1] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic glitch(input int s);
    @(negedge clk); key_raw[s-1] = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    key_raw[s-1] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic press_bouncy(input int s);
    @(negedge clk); key_raw[s-1] = 1'b1;
    @(negedge clk); key_raw[s-1] = 1'b0;
    @(negedge clk); key_raw[s-1] = 1'b1;
    repeat (2) @(negedge clk); key_raw[s-1] = 1'b0;
    @(negedge clk); key_raw[s-1] = 1'b1;
    repeat (6) @(negedge clk);
    key_raw[s-1] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic press_pair(input int a, input int b);
    @(negedge clk); key_raw[a-1] = 1'b1; key_raw[b-1] = 1'b1;
    repeat (6) @(negedge clk);
    key_raw = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_init();
    @(negedge clk); init_raw = 1'b1;
    repeat (6) @(negedge clk);
    init_raw = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic press_list(input int q[$]);
    foreach (q[i]) press(q[i]);
  endtask

  // Measures two whole flash phases at the LEDs.
  task automatic check_flash(input string req);
    logic [LW-1:0] prev;
    int ntr = 0;
    int last_t = 0;
    int run1 = -1;
    int run2 = -1;
    bit bad = 0;
    @(negedge clk); prev = led;
    for (int i = 0; i < 6 * FDIV; i++) begin
      @(negedge clk);
      if (led !== ALL_ON && led !== DARK) bad = 1;
      if (led !== prev) begin
        ntr++;
        if (ntr == 2) run1 = i - last_t;
        if (ntr == 3) run2 = i - last_t;
        last_t = i;
      end
      prev = led;
    end
    checks++;
    if (bad || run1 != FDIV || run2 != FDIV) begin
      fails++;
      $display("FAIL %s: flash runs=%0d,%0d bad=%0d expected runs=%0d,%0d", req, run1, run2, bad, FDIV, FDIV);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int q[$];
    repeat (4) @(negedge clk);
    expect_led(DARK, "R1 led dark in reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    expect_led(DARK, "R1 led dark after reset");

    // Ten symbols, no code: dark for nine, lock on the tenth.
    for (int i = 0; i < 9; i++) press(1);
    expect_led(DARK, "R10 open session dark after nine");
    press(1);
    expect_led(LOCK_PAT, "R5 lock after ten");

    // Locked: even the code is ignored.
    q = '{2, 3, 1, 4, 3};
    foreach (q[i]) begin
      press(q[i]);
      expect_led(LOCK_PAT, "R7 press ignored while locked");
    end

    do_init();
    expect_led(DARK, "R9 init leaves lock");

    // Direct code from the first symbol.
    q = '{2, 3, 1, 4};
    press_list(q);
    expect_led(DARK, "R4 partial code stays dark");
    press(3);
    expect_led(ALL_ON, "R4 code detected");
    check_flash("R8 flash period");

    // Presses after detection would overrun the limit if counted.
    for (int i = 0; i < 6; i++) press(1);
    check_flash("R7 presses ignored while flashing");
    do_init();
    expect_led(DARK, "R9 init leaves detection");

    // Code ending on the tenth symbol.
    q = '{2, 4, 1, 2, 3, 2, 3, 1, 4, 3};
    press_list(q);
    expect_led(ALL_ON, "R6 match on tenth beats lock");

    // Fallback when a 2 breaks a partial match.
    do_init();
    q = '{2, 2, 3, 1, 4, 3};
    press_list(q);
    expect_led(ALL_ON, "R4 fallback on repeated 2");
    do_init();
    q = '{2, 3, 1, 2, 3, 1, 4, 3};
    press_list(q);
    expect_led(ALL_ON, "R4 fallback after 2 3 1 2");

    // Short glitch gives no symbol.
    do_init();
    press(2); press(3); glitch(1);
    q = '{1, 4, 3};
    press_list(q);
    expect_led(ALL_ON, "R2 glitch ignored");

    // Bouncing press gives exactly one symbol.
    do_init();
    press(2); press_bouncy(3);
    q = '{1, 4, 3};
    press_list(q);
    expect_led(ALL_ON, "R2 bounce counted once");

    // Two buttons together give nothing; a long hold counts once.
    do_init();
    q = '{2, 3, 1, 4};
    press_list(q);
    press_pair(1, 2);
    press(3);
    expect_led(ALL_ON, "R3 two-button press gives no event");
    do_init();
    press(2); press(3); press_long(1); press(4); press(3);
    expect_led(ALL_ON, "R3 long hold counts once");

    // Two-button press does not count toward the limit.
    do_init();
    for (int i = 0; i < 9; i++) press(4);
    press_pair(3, 4);
    expect_led(DARK, "R3 pair not counted toward limit");
    press(4);
    expect_led(LOCK_PAT, "R5 lock on real tenth");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule